// File: doc/BRIEF.md
# Boot-Port Register Access Sequencer

This block sits on the host side of a shared parallel boot-ROM style port and turns one request into one complete single-byte access to a remote register. A request names a channel, a register index, a direction and a write value. The block forms the port address from a per-channel base plus four times the index, and loads it into the address register. It then raises the control/data register with the opcode, the ROM-select bit and (for writes) the data byte. It holds that word for a fixed number of cycles and samples the returned byte on the last of them. Finally it forces the control register back to zero and acknowledges.

Only one access is in flight at a time. While `busy` is high, new requests are dropped. `ack` marks the single cycle after the control register has returned to zero. For reads, `rd_data` then holds the captured byte, and it keeps that byte until the next read completes.

Top module: `romport_seq`

## Requirements
- R1: While reset is applied, `busy`, `ack`, `port_ctl`, `port_addr` and `rd_data` are all zero.
- R2: One cycle after a request is accepted, `port_addr` equals (BASE + channel*STRIDE + 4*index) modulo 2^18, and `port_ctl` is still zero in that cycle.
- R3: For a read, `port_ctl` carries bit 14 (read opcode) and bit 12 (ROM select), with bit 13 and bits 7:0 zero.
- R4: For a write, `port_ctl` carries bit 13 (write opcode), bit 12 (ROM select) and bits 7:0 equal to the low byte of the write value. Bit 14 is zero, and the upper bits of the write value never reach the port.
- R5: The opcode word is present for exactly HOLD consecutive cycles (default 20), starting two cycles after acceptance, and then `port_ctl` returns to zero.
- R6: A read captures bits 7:0 of `port_rdata` as they stand in the last cycle of the hold. Bits above 7 are discarded.
- R7: `ack` is high for exactly one cycle, the first cycle with `port_ctl` back at zero. `busy` is high from the cycle after acceptance through the `ack` cycle, and low otherwise.
- R8: A request presented while `busy` is high has no effect: the address, control word and captured data follow the access already in flight, and no second access follows.
- R9: `port_addr` does not change while `port_ctl` is non-zero, and it keeps the last accessed address while idle.
- R10: `rd_data` changes only when a read completes. A write leaves it at the previous read's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Request strobe, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_chan | input | CH_W | Channel selecting the base offset |
| req_idx | input | IDX_W | Register index within the channel |
| req_wdata | input | WIN_W | Write value; only bits 7:0 are used |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| port_addr | output | ADDR_W | Address register of the port |
| port_ctl | output | 16 | Control/data register of the port |
| port_rdata | input | 16 | Readback of the control/data register |

## Verification
The remote device in the bench returns a byte that changes every cycle of the hold. A sequencer that samples one cycle early or late therefore returns a byte that differs from the reference. Channel 3 with index 0xFF pushes the address sum past 18 bits, so a design that fails to wrap shows a wrong `port_addr`. Write values have non-zero upper bits, so a design that lets them leak into the control word is caught. Requests are injected in the address cycle, in the middle of the hold and in the `ack` cycle. A design that accepts any of them would reload the address or start a second access, and the reference model would flag it.

// File: rtl/romport_pkg.sv
package romport_pkg;
  localparam int BYTE_W      = 8;
  localparam int CTL_W       = 16;
  localparam int CTL_RD_BIT  = 14;
  localparam int CTL_WR_BIT  = 13;
  localparam int CTL_SEL_BIT = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_HOLD = 2'd2,
    ST_CLR  = 2'd3
  } seq_state_t;

  function automatic logic [CTL_W-1:0] op_word(input logic wr, input logic [BYTE_W-1:0] d);
    logic [CTL_W-1:0] w;
    w = '0;
    w[CTL_SEL_BIT] = 1'b1;
    if (wr) begin
      w[CTL_WR_BIT]   = 1'b1;
      w[BYTE_W-1:0]   = d;
    end else begin
      w[CTL_RD_BIT]   = 1'b1;
    end
    return w;
  endfunction
endpackage

// File: rtl/romport_rst_sync.sv
module romport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_sync = chain_q[1];
endmodule

// File: rtl/romport_addr_gen.sv
module romport_addr_gen #(
  parameter int          ADDR_W = 18,
  parameter int          CH_W   = 2,
  parameter int          IDX_W  = 8,
  parameter logic [31:0] BASE   = 32'h000C_0000,
  parameter logic [31:0] STRIDE = 32'h0002_0000
) (
  input  logic [CH_W-1:0]   chan,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int NUM_CH = 1 << CH_W;

  logic [ADDR_W-1:0] ch_base [NUM_CH];

  // Per-channel base offsets, wrapped to the port address width.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_base
    localparam logic [31:0] FULL = BASE + 32'(g) * STRIDE;
    assign ch_base[g] = FULL[ADDR_W-1:0];
  end

  assign addr = ch_base[chan] + (ADDR_W'(idx) << 2);
endmodule

// File: rtl/romport_hold_timer.sv
module romport_hold_timer #(
  parameter int HOLD = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic last
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start | run;
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = run && (cnt_q == CNT_W'(HOLD - 1));
endmodule

// File: rtl/romport_seq.sv
module romport_seq
  import romport_pkg::*;
#(
  parameter int          ADDR_W = 18,
  parameter int          CH_W   = 2,
  parameter int          IDX_W  = 8,
  parameter int          WIN_W  = 16,
  parameter int          HOLD   = 20,
  parameter logic [31:0] BASE   = 32'h000C_0000,
  parameter logic [31:0] STRIDE = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [WIN_W-1:0]  req_wdata,
  output logic              busy,
  output logic              ack,
  output logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] port_addr,
  output logic [CTL_W-1:0]  port_ctl,
  input  logic [CTL_W-1:0]  port_rdata
);
  logic rst_i;

  romport_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  logic [ADDR_W-1:0] gen_addr;

  romport_addr_gen #(
    .ADDR_W (ADDR_W),
    .CH_W   (CH_W),
    .IDX_W  (IDX_W),
    .BASE   (BASE),
    .STRIDE (STRIDE)
  ) u_addr (
    .chan (req_chan),
    .idx  (req_idx),
    .addr (gen_addr)
  );

  seq_state_t state_q, state_d;
  logic              hold_last;

  romport_hold_timer #(.HOLD(HOLD)) u_timer (
    .clk   (clk),
    .rst_n (rst_i),
    .start (state_q == ST_ADDR),
    .run   (state_q == ST_HOLD),
    .last  (hold_last)
  );

  logic [ADDR_W-1:0] addr_q;
  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic              wr_q;
  logic [BYTE_W-1:0] wd_q, rdat_q;
  logic              accept, ctl_en, rdat_en;

  // Upper bits of the wide inputs are dropped on purpose.
  logic unused_hi;
  assign unused_hi = ^{req_wdata[WIN_W-1:BYTE_W], port_rdata[CTL_W-1:BYTE_W]};

  always_comb begin
    accept  = req && (state_q == ST_IDLE);
    state_d = state_q;
    ctl_d   = ctl_q;
    ctl_en  = 1'b0;
    rdat_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) state_d = ST_ADDR;
      ST_ADDR: begin
        state_d = ST_HOLD;
        ctl_d   = op_word(wr_q, wd_q);
        ctl_en  = 1'b1;
      end
      ST_HOLD: if (hold_last) begin
        state_d = ST_CLR;
        ctl_d   = '0;
        ctl_en  = 1'b1;
        rdat_en = !wr_q;
      end
      ST_CLR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ctl_q   <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= gen_addr;
        wr_q   <= req_wr;
        wd_q   <= req_wdata[BYTE_W-1:0];
      end
      if (ctl_en)  ctl_q  <= ctl_d;
      if (rdat_en) rdat_q <= port_rdata[BYTE_W-1:0];
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign ack       = (state_q == ST_CLR);
  assign rd_data   = rdat_q;
  assign port_addr = addr_q;
  assign port_ctl  = ctl_q;
endmodule

// File: rtl/romport_seq_chk.sv
module romport_seq_chk
  import romport_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int HOLD   = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ack,
  input logic [ADDR_W-1:0] port_addr,
  input logic [CTL_W-1:0]  port_ctl
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (port_ctl != 0) run_q <= run_q + 16'd1;
    else                    run_q <= '0;
  end

  a_r3_read_word: assert property (@(posedge clk) disable iff (!rst_n)
    port_ctl[CTL_RD_BIT] |-> (port_ctl[CTL_SEL_BIT] && !port_ctl[CTL_WR_BIT] && port_ctl[BYTE_W-1:0] == '0));

  a_r4_write_word: assert property (@(posedge clk) disable iff (!rst_n)
    port_ctl[CTL_WR_BIT] |-> (port_ctl[CTL_SEL_BIT] && !port_ctl[CTL_RD_BIT]));

  a_r5_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(port_ctl) != 0 && port_ctl == 0) |-> (run_q == 16'(HOLD)));

  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r7_ack_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (port_ctl == 0 && $past(port_ctl) != 0 && busy));

  a_r7_busy_during_op: assert property (@(posedge clk) disable iff (!rst_n)
    (port_ctl != 0) |-> busy);

  a_r7_busy_ends_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ack));

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (port_ctl != 0) |-> $stable(port_addr));
endmodule

bind romport_seq romport_seq_chk #(.ADDR_W(ADDR_W), .HOLD(HOLD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .ack       (ack),
  .port_addr (port_addr),
  .port_ctl  (port_ctl)
);

// File: tb/romport_seq_tb.sv
module romport_seq_tb;
  localparam int          ADDR_W = 18;
  localparam int          CH_W   = 2;
  localparam int          IDX_W  = 8;
  localparam int          WIN_W  = 16;
  localparam int          HOLD   = 20;
  localparam logic [31:0] BASE   = 32'h000C_0000;
  localparam logic [31:0] STRIDE = 32'h0002_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, req_wr = 1'b0;
  logic [CH_W-1:0]   req_chan = '0;
  logic [IDX_W-1:0]  req_idx = '0;
  logic [WIN_W-1:0]  req_wdata = '0;
  logic              busy, ack;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] port_addr;
  logic [15:0]       port_ctl;
  logic [15:0]       port_rdata = '0;

  always #2 clk = ~clk;

  romport_seq #(.ADDR_W(ADDR_W), .CH_W(CH_W), .IDX_W(IDX_W), .WIN_W(WIN_W),
                .HOLD(HOLD), .BASE(BASE), .STRIDE(STRIDE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_chan(req_chan),
    .req_idx(req_idx), .req_wdata(req_wdata), .busy(busy), .ack(ack),
    .rd_data(rd_data), .port_addr(port_addr), .port_ctl(port_ctl),
    .port_rdata(port_rdata));

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint addr_of(input int ch, input int ix);
    return (longint'(BASE) + longint'(ch) * longint'(STRIDE) + longint'(ix) * 4) % (longint'(1) << ADDR_W);
  endfunction

  // Remote device: byte changes every cycle of a read hold; writes land when control clears.
  logic [7:0]  mem [256];
  int          rd_k = 0;
  logic [15:0] prev_ctl = '0;
  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);

  always @(negedge clk) begin
    if (prev_ctl[13] && port_ctl == 16'h0) mem[port_addr[9:2]] = prev_ctl[7:0];
    prev_ctl = port_ctl;
    if (port_ctl[14]) rd_k++; else rd_k = 0;
    port_rdata = {8'h5A + 8'(rd_k), mem[port_addr[9:2]] ^ 8'(rd_k)};
  end

  // Reference model: phase counter per access, -1 when idle.
  int          ph = -1;
  bit          m_wr = 0;
  logic [7:0]  m_wd = '0, e_rd = '0;
  longint      e_addr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = -1; e_addr = 0; e_rd = '0;
    end else begin
      if (ph == HOLD && !m_wr) e_rd = port_rdata[7:0];
      if (ph >= 0) begin
        ph++;
        if (ph == HOLD + 2) ph = -1;
      end else if (req) begin
        ph = 0;
        e_addr = addr_of(int'(req_chan), int'(req_idx));
        m_wr = req_wr;
        m_wd = req_wdata[7:0];
      end
    end
  end

  function automatic logic [15:0] exp_ctl();
    if (ph >= 1 && ph <= HOLD)
      return m_wr ? (16'h3000 | {8'h00, m_wd}) : 16'h5000;
    return 16'h0;
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(busy == (ph >= 0), "R7 busy", busy, ph >= 0);
      chk(ack == (ph == HOLD + 1), "R7 ack", ack, ph == HOLD + 1);
      chk(port_ctl == exp_ctl(), m_wr ? "R4/R5 port_ctl" : "R3/R5 port_ctl", port_ctl, exp_ctl());
      chk(longint'(port_addr) == e_addr, "R2/R8/R9 port_addr", port_addr, e_addr);
      chk(rd_data == e_rd, "R6/R10 rd_data", rd_data, e_rd);
    end
  end

  task automatic access(input bit wr, input int ch, input int ix, input int wd, input int intr_at);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_chan = CH_W'(ch); req_idx = IDX_W'(ix); req_wdata = WIN_W'(wd);
    @(negedge clk);
    req = 1'b0; req_chan = ~req_chan; req_idx = ~req_idx; req_wdata = ~req_wdata; req_wr = ~wr;
    if (intr_at >= 0) begin
      repeat (intr_at) @(negedge clk);
      req = 1'b1;                        // R8: intruding request while busy
      @(negedge clk);
      req = 1'b0;
      repeat (HOLD + 2 - intr_at) @(negedge clk);
    end else begin
      repeat (HOLD + 3) @(negedge clk);
    end
    chk(longint'(port_addr) == addr_of(ch, ix), "R9 idle address", port_addr, addr_of(ch, ix));
    chk(!busy && port_ctl == 0, "R8 idle after access", {busy, port_ctl}, 0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 200000);
    report();
  end

  logic [7:0] last_rd;
  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !ack, "R1 reset flags", {busy, ack}, 0);
    chk(port_ctl == 0 && port_addr == 0 && rd_data == 0, "R1 reset regs",
        {port_ctl, port_addr, rd_data}, 0);
    cmp_on = 1;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    access(0, 0, 8'h10, 0, -1);
    chk(rd_data == (mem[8'h10] ^ 8'(HOLD)), "R6 read last-cycle byte", rd_data, mem[8'h10] ^ 8'(HOLD));
    access(1, 1, 8'h10, 16'hBE3C, -1);                 // R4 upper byte must not leak
    chk(mem[8'h10] == 8'h3C, "R4 remote write byte", mem[8'h10], 8'h3C);
    access(0, 1, 8'h10, 16'hFFFF, -1);
    chk(rd_data == (8'h3C ^ 8'(HOLD)), "R6 read after write", rd_data, 8'h3C ^ 8'(HOLD));
    access(1, 3, 8'hFF, 16'hAA00, -1);                 // R2 address wraps at 18 bits
    chk(port_addr == 18'h203FC, "R2 address wrap", port_addr, 18'h203FC);
    access(0, 3, 8'hFF, 0, -1);
    access(0, 2, 8'h01, 0, 0);
    last_rd = rd_data;
    access(1, 0, 8'h22, 16'h0155, 7);
    chk(rd_data == last_rd, "R10 write keeps rd_data", rd_data, last_rd);
    access(0, 0, 8'h22, 0, HOLD + 1);
    chk(rd_data == (8'h55 ^ 8'(HOLD)), "R6 read back", rd_data, 8'h55 ^ 8'(HOLD));
    access(1, 2, 8'h80, 16'h00FF, -1);
    access(0, 2, 8'h80, 0, 3);
    chk(rd_data == (8'hFF ^ 8'(HOLD)), "R3 read after full-byte write", rd_data, 8'hFF ^ 8'(HOLD));
    repeat (4) @(negedge clk);
    report();
  end
endmodule